// File: doc/BRIEF.md
# Three-Line Rotating Window Generator

This block turns a raster stream of raw sensor pixels into a stream of 3x3 neighbourhoods, one per pixel, for a downstream demosaicing or filtering stage. Every accepted pixel is written into one of three single-line memory banks. The bank used changes with each new line of the frame, so the banks always hold the two most recent complete lines plus the line now arriving.

Once the line below a given line has been fully written, the block reads all three banks in parallel at the same column. It arranges the three words into the top, centre and bottom rows of the window in the order the rotation dictates. It then slides the window one column to the right per output. Neighbours that lie outside the frame are replaced by zero: left of the first column, right of the last column, above the first line and below the last line. The last line can only be completed once the frame is known to have ended, so it is emitted after the end-of-frame pulse. Four marker outputs say whether the centre pixel lies on the first or last column and on the first or last line.

The line length comes from an upstream measurement and must stay constant for the duration of a frame. The integrator must respect three timing rules. At least one idle cycle must separate consecutive lines. At least one idle cycle must separate the last pixel from the end-of-frame pulse. The first pixel of the next frame must come no sooner than line_len+2 cycles after that pulse.

Top module: `line3_window_gen`

## Requirements
- R1: Within a frame, line n (counting from 0) is written into bank n mod 3. The first line of every frame therefore goes into bank 0.
- R2: Each accepted pixel is stored in exactly one bank, at the column equal to the number of pixels accepted before it in the same line. Idle cycles inside a line do not shift the columns.
- R3: The window for centre (row r, column c) holds the pixels of rows r-1, r and r+1 at columns c-1, c and c+1. Entry (i, j), with i as the row from the top (0..2) and j as the column from the left (0..2), is carried on win_pix[(i*3+j)*PIX_W +: PIX_W].
- R4: Each input line of line_len pixels, where 1 <= line_len <= DEPTH, yields exactly line_len windows. Their centre columns run 0 to line_len-1 in ascending order.
- R5: In windows centred on the first line of a frame, the top row is zero.
- R6: In the window centred on column 0, the left column is zero. In the window centred on column line_len-1, the right column is zero.
- R7: The last line of a frame is emitted after end-of-frame, and its windows have an all-zero bottom row.
- R8: No window centred on line r appears before line r+1 has been completely written, or before end-of-frame has been seen for that frame.
- R9: End-of-frame restarts the bank rotation and the line and column counts, so that consecutive frames of different sizes are each windowed correctly.
- R10: win_first_col, win_last_col, win_first_row and win_last_row are high, together with win_valid, exactly for windows whose centre lies on column 0, column line_len-1, the first line and the last line respectively.
- R11: While reset is held and directly after it, win_valid and all markers are low and win_pix is zero.
- R12: A frame of a single line produces line_len windows after end-of-frame, each with both the top and the bottom row zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | Pixel on pix_data is accepted this cycle |
| pix_data | input | PIX_W | Raw pixel value |
| eof | input | 1 | One-cycle end-of-frame pulse, never together with pix_valid |
| line_len | input | $clog2(DEPTH)+1 | Pixels per line, 1 to DEPTH, constant within a frame |
| win_valid | output | 1 | A window is present on win_pix |
| win_pix | output | 9*PIX_W | 3x3 window, entry (row i, column j) at bits (i*3+j)*PIX_W |
| win_first_col | output | 1 | Centre pixel lies on column 0 |
| win_last_col | output | 1 | Centre pixel lies on the last column |
| win_first_row | output | 1 | Centre pixel lies on the first line |
| win_last_row | output | 1 | Centre pixel lies on the last line |

## Verification
The bench sweeps every line length from 1 to a small bank depth of 8, against frames of 1 to 5 lines. Because the line count runs past three, the rotation wraps within a frame and ends on each of the three banks. Frames are run back to back with different sizes, which shows whether end-of-frame really resets the rotation. Some frames insert idle cycles inside lines, which tells a column counter from a cycle counter. Inter-line gaps of one and two cycles stress the read-ahead of the window against the overwrite of the oldest bank. Every window is compared entry by entry with values computed from a position formula. A mismatch is classified as a padding error on one of the four edges or as a row or column mapping error.

// File: rtl/line3_pkg.sv
`timescale 1ns/1ps
package line3_pkg;
  localparam int NBANK = 3;

  typedef logic [1:0] bank_t;

  // describes how one output line maps banks onto window rows
  typedef struct packed {
    logic  topz;    // top row forced to zero (first line)
    logic  botz;    // bottom row forced to zero (last line)
    bank_t centre;  // bank holding the centre row
  } rowmap_t;

  function automatic bank_t bank_next(bank_t b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction

  function automatic bank_t bank_prev(bank_t b);
    return (b == 2'd0) ? 2'd2 : b - 2'd1;
  endfunction
endpackage

// File: rtl/line3_bank.sv
`timescale 1ns/1ps
module line3_bank #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [PIX_W-1:0] rdata
);
  logic [PIX_W-1:0] mem [DEPTH];

  // simple dual port, read returns the old word on an address collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/line3_wr_ctrl.sv
`timescale 1ns/1ps
module line3_wr_ctrl
  import line3_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int DEPTH = 2048,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = AW + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pix_valid,
  input  logic [PIX_W-1:0]       pix_data,
  input  logic                   eof,
  input  logic [LEN_W-1:0]       line_len,
  output logic [NBANK-1:0]       bank_we,
  output logic [AW-1:0]          waddr,
  output logic [PIX_W-1:0]       wdata,
  output logic                   req_valid,
  output rowmap_t                req_map
);
  bank_t            wbank;
  logic [LEN_W-1:0] wcol;
  logic [1:0]       nlines;   // completed lines this frame, saturates at 2
  logic             take;
  logic             line_done;

  assign take      = pix_valid && !eof;
  assign line_done = take && (wcol == line_len - 1'b1);
  assign waddr     = wcol[AW-1:0];
  assign wdata     = pix_data;

  for (genvar b = 0; b < NBANK; b++) begin : g_we
    assign bank_we[b] = take && (wbank == bank_t'(b));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbank     <= '0;
      wcol      <= '0;
      nlines    <= '0;
      req_valid <= 1'b0;
      req_map   <= '0;
    end else begin
      req_valid <= 1'b0;
      if (eof) begin
        if (nlines != 2'd0) begin
          req_valid <= 1'b1;
          req_map   <= '{topz: (nlines == 2'd1), botz: 1'b1, centre: bank_prev(wbank)};
        end
        wbank  <= '0;
        wcol   <= '0;
        nlines <= '0;
      end else if (take) begin
        if (line_done) begin
          wcol  <= '0;
          wbank <= bank_next(wbank);
          if (nlines != 2'd0) begin
            req_valid <= 1'b1;
            req_map   <= '{topz: (nlines == 2'd1), botz: 1'b0, centre: bank_prev(wbank)};
          end
          nlines <= (nlines == 2'd2) ? 2'd2 : nlines + 2'd1;
        end else begin
          wcol <= wcol + 1'b1;
        end
      end
    end
  end

  a_r2_one_bank: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_we));

  a_r9_restart_bank0: assert property (@(posedge clk) disable iff (rst)
    eof |=> (!pix_valid || eof || bank_we == 3'b001));

  a_r4_len_range: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (line_len != '0 && line_len <= LEN_W'(DEPTH)));
endmodule

// File: rtl/line3_rd_ctrl.sv
`timescale 1ns/1ps
module line3_rd_ctrl
  import line3_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] line_len,
  input  logic             req_valid,
  input  rowmap_t          req_map,
  output logic             rd_en,
  output logic [AW-1:0]    raddr,
  output logic             p1_valid,
  output logic             p1_slot0,
  output logic             p1_slot1,
  output logic             p1_flush,
  output rowmap_t          p1_map
);
  logic             active;
  logic [LEN_W-1:0] sc;       // slot: 0..rlen-1 read, rlen flush
  logic [LEN_W-1:0] rlen;
  rowmap_t          cur_map;
  logic             pend;
  rowmap_t          pend_map;
  logic             at_last;
  logic             go;

  assign at_last = active && (sc == rlen);
  assign go      = (req_valid || pend) && (!active || at_last);
  assign rd_en   = active && !at_last;
  assign raddr   = sc[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      sc       <= '0;
      rlen     <= '0;
      cur_map  <= '0;
      pend     <= 1'b0;
      pend_map <= '0;
    end else if (go) begin
      active  <= 1'b1;
      sc      <= '0;
      rlen    <= line_len;
      cur_map <= pend ? pend_map : req_map;
      pend    <= pend && req_valid;
      if (pend && req_valid) pend_map <= req_map;
    end else begin
      if (req_valid) begin
        pend     <= 1'b1;
        pend_map <= req_map;
      end
      if (at_last) active <= 1'b0;
      else if (active) sc <= sc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_valid <= 1'b0;
      p1_slot0 <= 1'b0;
      p1_slot1 <= 1'b0;
      p1_flush <= 1'b0;
      p1_map   <= '0;
    end else begin
      p1_valid <= active;
      p1_slot0 <= active && (sc == '0);
      p1_slot1 <= active && (sc == LEN_W'(1));
      p1_flush <= at_last;
      p1_map   <= cur_map;
    end
  end

  a_r8_single_pending: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !pend);
endmodule

// File: rtl/line3_win_form.sv
`timescale 1ns/1ps
module line3_win_form
  import line3_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NBANK-1:0][PIX_W-1:0] rdata,
  input  logic                        p1_valid,
  input  logic                        p1_slot0,
  input  logic                        p1_slot1,
  input  logic                        p1_flush,
  input  rowmap_t                     p1_map,
  output logic                        win_valid,
  output logic [9*PIX_W-1:0]          win_pix,
  output logic                        win_first_col,
  output logic                        win_last_col,
  output logic                        win_first_row,
  output logic                        win_last_row
);
  // one column of the window, index 0 = top row
  typedef logic [2:0][PIX_W-1:0] column_t;

  column_t col_l, col_m, col_r;
  column_t newcol;

  always_comb begin
    newcol = '0;
    if (!p1_flush) begin
      newcol[0] = p1_map.topz ? '0 : rdata[bank_prev(p1_map.centre)];
      newcol[1] = rdata[p1_map.centre];
      newcol[2] = p1_map.botz ? '0 : rdata[bank_next(p1_map.centre)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_l         <= '0;
      col_m         <= '0;
      col_r         <= '0;
      win_valid     <= 1'b0;
      win_first_col <= 1'b0;
      win_last_col  <= 1'b0;
      win_first_row <= 1'b0;
      win_last_row  <= 1'b0;
    end else begin
      if (p1_valid) begin
        col_l <= p1_slot0 ? '0 : col_m;
        col_m <= p1_slot0 ? '0 : col_r;
        col_r <= newcol;
      end
      win_valid     <= p1_valid && !p1_slot0;
      win_first_col <= p1_valid && p1_slot1;
      win_last_col  <= p1_valid && p1_flush;
      win_first_row <= p1_valid && !p1_slot0 && p1_map.topz;
      win_last_row  <= p1_valid && !p1_slot0 && p1_map.botz;
    end
  end

  for (genvar r = 0; r < 3; r++) begin : g_row
    assign win_pix[(r*3+0)*PIX_W +: PIX_W] = col_l[r];
    assign win_pix[(r*3+1)*PIX_W +: PIX_W] = col_m[r];
    assign win_pix[(r*3+2)*PIX_W +: PIX_W] = col_r[r];
  end

  a_r6_left_pad: assert property (@(posedge clk) disable iff (rst)
    (win_valid && win_first_col) |-> (col_l == '0));

  a_r6_right_pad: assert property (@(posedge clk) disable iff (rst)
    (win_valid && win_last_col) |-> (col_r == '0));

  a_r5_top_pad: assert property (@(posedge clk) disable iff (rst)
    (win_valid && win_first_row) |-> (col_l[0] == '0 && col_m[0] == '0 && col_r[0] == '0));

  a_r7_bottom_pad: assert property (@(posedge clk) disable iff (rst)
    (win_valid && win_last_row) |-> (col_l[2] == '0 && col_m[2] == '0 && col_r[2] == '0));
endmodule

// File: rtl/line3_window_gen.sv
`timescale 1ns/1ps
module line3_window_gen
  import line3_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int DEPTH = 2048,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_valid,
  input  logic [PIX_W-1:0]   pix_data,
  input  logic               eof,
  input  logic [LEN_W-1:0]   line_len,
  output logic               win_valid,
  output logic [9*PIX_W-1:0] win_pix,
  output logic               win_first_col,
  output logic               win_last_col,
  output logic               win_first_row,
  output logic               win_last_row
);
  initial begin
    a_r4_depth_pow2: assert ((DEPTH & (DEPTH - 1)) == 0 && DEPTH >= 2)
      else $error("DEPTH must be a power of two");
  end

  logic [NBANK-1:0]            bank_we;
  logic [AW-1:0]               waddr;
  logic [PIX_W-1:0]            wdata;
  logic                        req_valid;
  rowmap_t                     req_map;
  logic                        rd_en;
  logic [AW-1:0]               raddr;
  logic [NBANK-1:0][PIX_W-1:0] rdata;
  logic                        p1_valid, p1_slot0, p1_slot1, p1_flush;
  rowmap_t                     p1_map;

  line3_wr_ctrl #(.PIX_W(PIX_W), .DEPTH(DEPTH)) u_wr (
    .clk, .rst, .pix_valid, .pix_data, .eof, .line_len,
    .bank_we, .waddr, .wdata, .req_valid, .req_map
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    line3_bank #(.PIX_W(PIX_W), .DEPTH(DEPTH)) u_bank (
      .clk   (clk),
      .we    (bank_we[b]),
      .waddr (waddr),
      .wdata (wdata),
      .re    (rd_en),
      .raddr (raddr),
      .rdata (rdata[b])
    );
  end

  line3_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk, .rst, .line_len, .req_valid, .req_map,
    .rd_en, .raddr, .p1_valid, .p1_slot0, .p1_slot1, .p1_flush, .p1_map
  );

  line3_win_form #(.PIX_W(PIX_W)) u_win (
    .clk, .rst, .rdata, .p1_valid, .p1_slot0, .p1_slot1, .p1_flush, .p1_map,
    .win_valid, .win_pix, .win_first_col, .win_last_col, .win_first_row, .win_last_row
  );
endmodule

// File: tb/tb_line3_window_gen.sv
`timescale 1ns/1ps
module tb_line3_window_gen;
  localparam int W     = 8;
  localparam int DEPTH = 8;
  localparam int LEN_W = $clog2(DEPTH) + 1;
  localparam int MAXF  = 64;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pix_valid = 1'b0;
  logic [W-1:0]     pix_data = '0;
  logic             eof = 1'b0;
  logic [LEN_W-1:0] line_len = LEN_W'(1);
  logic             win_valid;
  logic [9*W-1:0]   win_pix;
  logic             win_first_col, win_last_col, win_first_row, win_last_row;

  always #2.5 clk = ~clk;

  line3_window_gen #(.PIX_W(W), .DEPTH(DEPTH)) dut (
    .clk, .rst, .pix_valid, .pix_data, .eof, .line_len,
    .win_valid, .win_pix, .win_first_col, .win_last_col, .win_first_row, .win_last_row
  );

  int nerr = 0;
  int nchk = 0;
  bit finished = 0;
  int frame_lines [MAXF];
  int frame_len   [MAXF];
  int wcount      [MAXF];
  int drv_frame = -1;
  int drv_lines = 0;
  int drv_eof   = 0;
  int m_f = 0, m_r = 0, m_c = 0;

  function automatic int pv(int f, int r, int c);
    return ((f * 37 + r * 11 + c * 3 + 5) % 255) + 1;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // window monitor: compare every window with the positional formula
  always @(negedge clk) begin
    if (!rst && win_valid && !finished) begin
      int n, l, bad_pos, got, exp_v;
      string tag;
      if (m_f >= MAXF) begin
        nchk++; nerr++;
        $display("FAIL R4 window beyond last frame: got frame %0d expected < %0d", m_f, MAXF);
      end else begin
        n = frame_lines[m_f];
        l = frame_len[m_f];
        wcount[m_f]++;
        bad_pos = -1; got = 0; exp_v = 0; tag = "R3";
        for (int i = 0; i < 3; i++) begin
          for (int j = 0; j < 3; j++) begin
            int rr, cc, e, a;
            rr = m_r + i - 1;
            cc = m_c + j - 1;
            e = (rr < 0 || rr >= n || cc < 0 || cc >= l) ? 0 : pv(m_f, rr, cc);
            a = int'(win_pix[(i*3+j)*W +: W]);
            if (a != e && bad_pos < 0) begin
              bad_pos = i*3+j; got = a; exp_v = e;
              if (n == 1 && (rr < 0 || rr >= n)) tag = "R12";
              else if (rr < 0) tag = "R5";
              else if (rr >= n) tag = "R7";
              else if (cc < 0 || cc >= l) tag = "R6";
              else tag = "R3";
            end
          end
        end
        nchk++;
        if (bad_pos >= 0) begin
          nerr++;
          $display("FAIL %s frame %0d row %0d col %0d entry %0d: got %0d expected %0d (bank order R1, column store R2)",
                   tag, m_f, m_r, m_c, bad_pos, got, exp_v);
        end
        // R10 markers
        nchk++;
        if (win_first_col != (m_c == 0) || win_last_col != (m_c == l-1) ||
            win_first_row != (m_r == 0) || win_last_row != (m_r == n-1)) begin
          nerr++;
          $display("FAIL R10 frame %0d row %0d col %0d: got markers %b%b%b%b expected %b%b%b%b",
                   m_f, m_r, m_c, win_first_col, win_last_col, win_first_row, win_last_row,
                   m_c == 0, m_c == l-1, m_r == 0, m_r == n-1);
        end
        // R8 ordering against input progress
        nchk++;
        if (!(drv_frame > m_f || drv_eof != 0 || drv_lines >= m_r + 2)) begin
          nerr++;
          $display("FAIL R8 frame %0d row %0d: got window with %0d lines written expected >= %0d",
                   m_f, m_r, drv_lines, m_r + 2);
        end
        // R9 restart: first window of a later frame
        if (m_f > 0 && m_r == 0 && m_c == 0) begin
          nchk++;
          if (!(win_first_row && win_first_col) || int'(win_pix[4*W +: W]) != pv(m_f, 0, 0)) begin
            nerr++;
            $display("FAIL R9 frame %0d start: got centre %0d expected %0d",
                     m_f, win_pix[4*W +: W], pv(m_f, 0, 0));
          end
        end
        m_c++;
        if (m_c >= l) begin
          m_c = 0; m_r++;
          if (m_r >= n) begin m_r = 0; m_f++; end
        end
      end
    end
  end

  task automatic send_frame(int f, int n, int l, int gap, bit bubbles);
    line_len = LEN_W'(l);
    frame_lines[f] = n;
    frame_len[f] = l;
    drv_lines = 0;
    drv_eof = 0;
    drv_frame = f;
    for (int r = 0; r < n; r++) begin
      for (int c = 0; c < l; c++) begin
        if (bubbles && (c % 3 == 2)) begin
          pix_valid = 1'b0;
          tick();
        end
        pix_valid = 1'b1;
        pix_data = W'(pv(f, r, c));
        tick();
      end
      pix_valid = 1'b0;
      drv_lines = r + 1;
      repeat (gap) tick();
    end
    eof = 1'b1;
    tick();
    eof = 1'b0;
    drv_eof = 1;
    repeat (l + 6) tick();
  endtask

  task automatic check_idle(string when);
    nchk++;
    if (win_valid || win_first_col || win_last_col || win_first_row || win_last_row || win_pix != '0) begin
      nerr++;
      $display("FAIL R11 %s: got valid %b markers %b%b%b%b pix %h expected all zero",
               when, win_valid, win_first_col, win_last_col, win_first_row, win_last_row, win_pix);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL R4 watchdog: got no completion expected end of stimulus");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int f;
    for (int k = 0; k < MAXF; k++) begin
      frame_lines[k] = 0; frame_len[k] = 1; wcount[k] = 0;
    end
    repeat (4) tick();
    check_idle("during reset");
    rst = 1'b0;
    tick();
    check_idle("after reset");
    repeat (3) tick();
    check_idle("idle after reset");
    f = 0;
    for (int l = 1; l <= DEPTH; l++) begin
      for (int n = 1; n <= 5; n++) begin
        send_frame(f, n, l, 1 + (f % 2), (f % 3) == 2);
        f++;
      end
    end
    repeat (30) tick();
    for (int k = 0; k < f; k++) begin
      nchk++;
      if (wcount[k] != frame_lines[k] * frame_len[k]) begin
        nerr++;
        $display("FAIL %s frame %0d count: got %0d expected %0d",
                 (frame_lines[k] == 1) ? "R12" : "R4", k, wcount[k], frame_lines[k] * frame_len[k]);
      end
    end
    nchk++;
    if (m_f != f) begin
      nerr++;
      $display("FAIL R4 frames completed: got %0d expected %0d", m_f, f);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule